// File: doc/BRIEF.md
# Converter Host Port with Wait Stretch

This block is the processor-facing side of a data converter. A host reaches it through an active-low chip select, active-low read and write strobes and a single address bit. Reads return either the oldest converted result held in a small internal FIFO or a status/control word. Writes reach only the control field of that word. The converter side fills the FIFO through a push port and reports its busy state on an input.

Register writes do not follow the host strobe directly. The write strobe is sampled at the falling clock edge, so only a strobe that overlaps the clock-low phase produces an internal enable, and the control field commits at the following rising edge. If the host starts an access while the conversion-start pulse is active, the port raises a wait output. Wait stays high until one clock after the start pulse ends, and then the held access completes as usual.

Top module: `conv_host_port`

## Requirements
- R1: After reset the FIFO is empty, the control field and underflow flag are zero, and wait is low; a status read returns 0 when the busy input is low.
- R2: A read with chip select and read strobe low and the address bit at 0 returns the oldest stored word, and one word is removed at the release of that read strobe, so words leave in push order.
- R3: A read with the address bit at 1 returns the 16-bit status word: bits 15:10 the control field, bit 9 the underflow flag, bit 8 the busy input, bits 7:5 zero, bits 4:0 the FIFO word count.
- R4: A write with chip select and write strobe low and the address bit at 1 stores write-data bits 6:1 into the control field.
- R5: A write with the address bit at 0 is ignored and changes no state: control field, underflow flag and FIFO contents stay as they were.
- R6: A write takes effect only if the strobe is active at a falling clock edge; a strobe that begins and ends within one clock-high phase writes nothing.
- R7: A FIFO read while the FIFO is empty returns zero and sets the underflow flag, which stays set until a flush.
- R8: A register write with write-data bit 0 at 1 empties the FIFO and clears the underflow flag; the bit is a command and is not stored.
- R9: An access that starts while the start input is low drives wait high; wait falls one clock after start returns high, and a held write then commits.
- R10: The FIFO holds 16 words; a push while it is full is dropped and the count never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | 0 selects FIFO, 1 selects status/control |
| wdata | input | 8 | Host write data |
| rdata | output | 16 | Host read data, zero when no read is active |
| start_n | input | 1 | Conversion-start pulse, active low |
| wait_o | output | 1 | Holds the host in a wait state |
| push | input | 1 | Converter pushes a result this cycle |
| push_data | input | 16 | Converter result |
| busy | input | 1 | Converter busy flag, reported in status |
| ctrl | output | 6 | Stored control field |

## Verification
On every cycle the assertions check that wait is only raised during an access and drops once start has been high for a clock, that the count never exceeds the depth, that a pop of a non-empty FIFO lowers the count by one, that an empty pop raises underflow, that an empty FIFO read returns zero, and that the control field moves only after a sampled write enable. The bench scenarios show what needs whole transactions: the push order coming back, the status layout, a strobe too short to reach the clock-low phase, ignored address-0 writes, flush, the full-FIFO drop, and a held write landing after wait releases.

// File: rtl/chp_pkg.sv
package chp_pkg;
  localparam int FIFO_DEPTH = 16;
  localparam int DATA_W     = 16;
  localparam int CTRL_W     = 6;
  localparam int WD_W       = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int PAD_W      = DATA_W - CTRL_W - 2 - CNT_W;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic              underflow;
    logic              busy;
    logic [PAD_W-1:0]  pad;
    logic [CNT_W-1:0]  count;
  } status_t;
endpackage

// File: rtl/chp_decode.sv
module chp_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic addr,
  input  logic start_n,
  output logic rd_fifo,
  output logic rd_stat,
  output logic wr_req,
  output logic pop,
  output logic wait_o
);
  logic acc_rd, acc_wr, start_act;
  logic hold_q, hold_d;
  logic rdq_q, rdq_d;

  always_comb begin
    acc_rd    = !cs_n && !rd_n;
    acc_wr    = !cs_n && !wr_n;
    start_act = !start_n;
    wait_o    = (acc_rd || acc_wr) && (start_act || hold_q);
    rd_fifo   = acc_rd && !addr;
    rd_stat   = acc_rd && addr;
    wr_req    = acc_wr && addr && !wait_o;
    pop       = rdq_q && !rd_fifo;
    hold_d    = start_act;
    rdq_d     = rd_fifo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rdq_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rdq_q  <= rdq_d;
    end
  end

  // R9: wait only accompanies an access
  a_r9_wait_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (!cs_n && (!rd_n || !wr_n)));

  // R9: one clock after start is seen high, wait has fallen
  a_r9_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && $past(start_n)) |-> !wait_o);
endmodule

// File: rtl/chp_ctrl_reg.sv
module chp_ctrl_reg
  import chp_pkg::*;
#(
  parameter int CW = CTRL_W,
  parameter int DW = WD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] ctrl_o,
  output logic          flush_o
);
  logic          we_lo;
  logic [DW-1:0] dat_lo;
  logic [CW-1:0] ctrl_q, ctrl_d;

  // Falling edge: strobe overlapping the clock-low phase forms the enable
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo  <= 1'b0;
      dat_lo <= '0;
    end else begin
      we_lo <= wr_req;
      if (wr_req) dat_lo <= wdata;
    end
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    if (we_lo) ctrl_d = dat_lo[CW:1];
    flush_o = we_lo && dat_lo[0];
    ctrl_o  = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R5/R6: the field moves only after a sampled enable
  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_lo |=> $stable(ctrl_q));
endmodule

// File: rtl/chp_fifo.sv
module chp_fifo
  import chp_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int W     = DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       underflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          uf_q, uf_d;
  logic          push_ok, pop_ok, empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    empty   = (cnt_q == '0);
    push_ok = push && (cnt_q != CW'(DEPTH));
    pop_ok  = pop && !empty;
    wp_d    = push_ok ? bump(wp_q) : wp_q;
    rp_d    = pop_ok ? bump(rp_q) : rp_q;
    cnt_d   = cnt_q + CW'(push_ok) - CW'(pop_ok);
    uf_d    = uf_q || (pop && empty);
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      uf_d  = 1'b0;
    end
    head      = empty ? '0 : mem[rp_q];
    count     = cnt_q;
    underflow = uf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      uf_q  <= uf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= push_data;
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r2_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r7_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == '0 && !flush) |=> uf_q);
endmodule

// File: rtl/conv_host_port.sv
module conv_host_port
  import chp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              addr,
  input  logic [WD_W-1:0]   wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              start_n,
  output logic              wait_o,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              busy,
  output logic [CTRL_W-1:0] ctrl
);
  logic [1:0]       rst_sync;
  logic             rst_i;
  logic             rd_fifo, rd_stat, wr_req, pop, flush, uf;
  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0] count;
  status_t          stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  chp_decode u_dec (
    .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .start_n(start_n), .rd_fifo(rd_fifo), .rd_stat(rd_stat),
    .wr_req(wr_req), .pop(pop), .wait_o(wait_o)
  );

  chp_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_i), .wr_req(wr_req), .wdata(wdata),
    .ctrl_o(ctrl), .flush_o(flush)
  );

  chp_fifo u_fifo (
    .clk(clk), .rst_n(rst_i), .push(push), .push_data(push_data),
    .pop(pop), .flush(flush), .head(head), .count(count), .underflow(uf)
  );

  always_comb begin
    stat.ctrl      = ctrl;
    stat.underflow = uf;
    stat.busy      = busy;
    stat.pad       = '0;
    stat.count     = count;
    rdata = '0;
    if (rd_fifo)      rdata = head;
    else if (rd_stat) rdata = stat;
  end

  // R7: an empty FIFO read shows zero
  a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_fifo && count == '0) |-> (rdata == '0));
endmodule

// File: tb/conv_host_port_test.sv
`timescale 1ns/100ps
module conv_host_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_n, wr_n, addr, start_n, push, busy;
  logic [7:0]  wdata;
  logic [15:0] rdata, push_data;
  logic        wait_o;
  logic [5:0]  ctrl;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  conv_host_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .start_n(start_n),
    .wait_o(wait_o), .push(push), .push_data(push_data), .busy(busy),
    .ctrl(ctrl)
  );

  function automatic logic [15:0] st(input logic [5:0] c, input logic u,
                                     input logic b, input logic [4:0] n);
    return {c, u, b, 3'b000, n};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; wdata = 0;
  endtask

  task automatic push_word(input logic [15:0] d);
    push = 1; push_data = d; step(); push = 0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] v);
    cs_n = 0; rd_n = 0; addr = a; #2; v = rdata;
    step(); idle(); step();
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    cs_n = 0; wr_n = 0; addr = a; wdata = d;
    step(); idle(); step();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 wait", {15'b0, wait_o}, 16'h0);
    bus_read(1, v); check("R1 status", v, 16'h0000);
  endtask

  task automatic t_order();
    logic [15:0] v;
    push_word(16'hA001); push_word(16'hB002); push_word(16'hC003); step();
    bus_read(1, v); check("R3 status count", v, st(0, 0, 0, 3));
    bus_read(0, v); check("R2 first", v, 16'hA001);
    bus_read(0, v); check("R2 second", v, 16'hB002);
    bus_read(0, v); check("R2 third", v, 16'hC003);
    bus_read(1, v); check("R2 drained", v, st(0, 0, 0, 0));
  endtask

  task automatic t_underflow();
    logic [15:0] v;
    bus_read(0, v); check("R7 empty data", v, 16'h0000);
    bus_read(1, v); check("R7 flag set", v, st(0, 1, 0, 0));
    bus_write(1, 8'h01);
    bus_read(1, v); check("R8 flag cleared", v, st(0, 0, 0, 0));
  endtask

  task automatic t_ctrl_write();
    logic [15:0] v;
    busy = 1;
    bus_write(1, 8'h2A);
    bus_read(1, v); check("R4 ctrl field", v, st(6'h15, 0, 1, 0));
    check("R4 ctrl port", {10'b0, ctrl}, 16'h0015);
    busy = 0;
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    push_word(16'h5A5A); step();
    bus_write(0, 8'hFF);
    bus_read(1, v); check("R5 state kept", v, st(6'h15, 0, 0, 1));
    bus_read(0, v); check("R5 fifo kept", v, 16'h5A5A);
  endtask

  task automatic t_short_strobe();
    logic [15:0] v;
    @(posedge clk); #0.5;
    cs_n = 0; wr_n = 0; addr = 1; wdata = 8'h7E;
    #1; idle();
    step(); step();
    bus_read(1, v); check("R6 no write in high phase", v, st(6'h15, 0, 0, 0));
  endtask

  task automatic t_flush();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) push_word(16'(i + 16'h10));
    step();
    bus_write(1, 8'h09);
    bus_read(1, v); check("R8 flushed", v, st(6'h04, 0, 0, 0));
  endtask

  task automatic t_wait();
    logic [15:0] v;
    start_n = 0; step();
    cs_n = 0; wr_n = 0; addr = 1; wdata = 8'h0C;
    #2; check("R9 wait raised", {15'b0, wait_o}, 16'h1);
    step(); start_n = 1;
    #2; check("R9 wait held one clock", {15'b0, wait_o}, 16'h1);
    step();
    #2; check("R9 wait released", {15'b0, wait_o}, 16'h0);
    check("R9 no commit while held", {10'b0, ctrl}, 16'h0004);
    step(); idle(); step();
    bus_read(1, v); check("R9 held write commits", v, st(6'h06, 0, 0, 0));
  endtask

  task automatic t_full();
    logic [15:0] v;
    for (int i = 0; i < 17; i++) push_word(16'(16'h100 + i));
    step();
    bus_read(1, v); check("R10 count capped", v, st(6'h06, 0, 0, 16));
    for (int i = 0; i < 16; i++) begin
      bus_read(0, v); check("R10 order", v, 16'(16'h100 + i));
    end
    bus_read(1, v); check("R10 drained", v, st(6'h06, 0, 0, 0));
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; start_n = 1; push = 0; push_data = 0; busy = 0;
    idle();
    step(); step();
    rst_n = 1;
    step(); step(); step();
    t_reset();
    t_order();
    t_underflow();
    t_ctrl_write();
    t_ignored();
    t_short_strobe();
    t_flush();
    t_wait();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule